// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

This block tracks, for every architectural register of an in-order issue core, whether a result destined for that register is still in flight. Each register owns one pending bit. Issuing an instruction that will write a register raises its bit. The bit falls again when the write-back path writes that register, or when the owning unit finishes without ever producing the result.

Before an instruction issues, its source registers are presented on a check port. The block answers in the same cycle whether any enabled source still has a write outstanding, which is a read-after-write hazard. Several units can raise or clear bits in the same cycle; their requests are merged into one set mask and one clear mask. A parameter picks the register select encoding: either a binary index or a one-hot vector.

Top module: `wr_pend_scoreboard`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every pending bit and every latched write flag.
- R2: At a rising edge where unit d has `iss_sel[d]` and `iss_wr[d]` both high, the pending bit of its destination register is 1 afterwards; with `iss_wr[d]` low the issue raises no bit.
- R3: At a rising edge where `wb_en[d]` is high, the pending bit of register `wb_dst` of unit d is 0 afterwards, unless the same edge also sets it.
- R4: Each unit latches `iss_wr` and its destination at issue. At an edge where the unit reports `unit_done` high, its latched flag is 1 and `res_ok` is 0, the latched destination's bit is cleared. With `res_ok` high this path clears nothing.
- R5: While a unit is not busy and not issuing, its latched write flag is dropped at every edge, so a later `unit_done` with `res_ok` low clears nothing.
- R6: `hazard` is combinational: it is 1 exactly when `chk_active` is high and at least one source with its `src_en` bit high selects a register whose pending bit is 1. Disabled sources have no effect.
- R7: When one edge both sets and clears the same bit, the set wins and the bit reads 1.
- R8: Set and clear requests from all units in one cycle are OR-combined, so two units can raise or clear two registers at once.
- R9: With `ONEHOT`=0 a select is a binary index where value i names register i, i.e. bit i of `pend`. With `ONEHOT`=1 a select is an `NREG`-bit vector whose bit i names register i.
- R10: A pending bit that is neither set nor cleared at an edge keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| iss_sel | input | NDST | Per-unit issue strobe (unit selected this cycle) |
| iss_wr | input | NDST | Per-unit write flag of the issuing instruction |
| iss_dst | input | NDST*SELW | Per-unit destination select at issue |
| wb_en | input | NDST | Per-unit write-back strobe |
| wb_dst | input | NDST*SELW | Per-unit register written back |
| unit_busy | input | NDST | Per-unit busy flag |
| unit_done | input | NDST | Per-unit completion strobe |
| res_ok | input | NDST | Per-unit result-valid flag at completion |
| chk_active | input | 1 | An instruction is being checked for issue |
| src_en | input | NSRC | Per-source enable of the check |
| src_sel | input | NSRC*SELW | Per-source register select |
| pend | output | NREG | Pending-write bit per register |
| hazard | output | 1 | Read-after-write hazard on an enabled source |

SELW is `$clog2(NREG)` when `ONEHOT`=0 and `NREG` when `ONEHOT`=1.

## Verification
`hazard` depends only on the present inputs and the present pending bits, so it is due in the same cycle as the stimulus. The bench samples it a few nanoseconds after driving the inputs at the falling edge, before the next rising edge. `pend` reflects the stimulus one rising edge later, and the bench compares it at the following falling edge against a behavioural model that was advanced at that same rising edge. A binary-select instance and a one-hot instance take the same stimulus and are both held to the model.

// File: rtl/wr_pend_scoreboard.sv
module wr_pend_scoreboard #(
  parameter int NREG   = 32,
  parameter int NSRC   = 3,
  parameter int NDST   = 2,
  parameter bit ONEHOT = 1'b0,
  localparam int IDXW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int SELW  = ONEHOT ? NREG : IDXW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NDST-1:0]      iss_sel,
  input  logic [NDST-1:0]      iss_wr,
  input  logic [NDST*SELW-1:0] iss_dst,
  input  logic [NDST-1:0]      wb_en,
  input  logic [NDST*SELW-1:0] wb_dst,
  input  logic [NDST-1:0]      unit_busy,
  input  logic [NDST-1:0]      unit_done,
  input  logic [NDST-1:0]      res_ok,
  input  logic                 chk_active,
  input  logic [NSRC-1:0]      src_en,
  input  logic [NSRC*SELW-1:0] src_sel,
  output logic [NREG-1:0]      pend,
  output logic                 hazard
);

  function automatic logic [NREG-1:0] to_mask(input logic [SELW-1:0] s);
    if (ONEHOT) return NREG'(s);
    else        return NREG'(1) << s;
  endfunction

  logic [NDST-1:0]           lat_wr;
  logic [NDST-1:0][SELW-1:0] lat_dst;
  logic [NREG-1:0]           set_mask, clr_mask, chk_mask;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int d = 0; d < NDST; d++) begin
      if (iss_sel[d] && iss_wr[d]) set_mask |= to_mask(iss_dst[d*SELW +: SELW]);
      if (wb_en[d])                clr_mask |= to_mask(wb_dst[d*SELW +: SELW]);
      if (unit_done[d] && lat_wr[d] && !res_ok[d])
        clr_mask |= to_mask(lat_dst[d]);
    end
  end

  always_comb begin
    chk_mask = '0;
    for (int s = 0; s < NSRC; s++)
      if (src_en[s]) chk_mask |= to_mask(src_sel[s*SELW +: SELW]);
  end

  assign hazard = chk_active & (|(chk_mask & pend));

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    for (int d = 0; d < NDST; d++) begin
      if (rst) begin
        lat_wr[d]  <= 1'b0;
        lat_dst[d] <= '0;
      end else if (iss_sel[d]) begin
        lat_wr[d]  <= iss_wr[d];
        lat_dst[d] <= iss_dst[d*SELW +: SELW];
      end else if (!unit_busy[d]) begin
        lat_wr[d]  <= 1'b0;
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pend == '0);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    armed |-> (pend & $past(set_mask)) == $past(set_mask));

  assert_clear_applied_R3: assert property (@(posedge clk) disable iff (rst)
    armed |-> (pend & $past(clr_mask) & ~$past(set_mask)) == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((pend ^ $past(pend)) & ~($past(set_mask) | $past(clr_mask))) == '0);

  assert_hazard_gated_R6: assert property (@(posedge clk) disable iff (rst)
    hazard |-> (chk_active && (|pend)));

endmodule

// File: tb/tb_wr_pend_scoreboard.sv
module tb_wr_pend_scoreboard;
  localparam int NREG = 32, NSRC = 3, NDST = 2, IDXW = 5;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [NDST-1:0] iss_sel, iss_wr, wb_en, busy, done, rok;
  logic chk;
  logic [NSRC-1:0] src_en;
  int iss_idx[NDST], wb_idx[NDST], src_idx[NSRC];

  logic [NDST*IDXW-1:0] b_iss, b_wb;
  logic [NSRC*IDXW-1:0] b_src;
  logic [NDST*NREG-1:0] o_iss, o_wb;
  logic [NSRC*NREG-1:0] o_src;

  always_comb begin
    for (int d = 0; d < NDST; d++) begin
      b_iss[d*IDXW +: IDXW] = IDXW'(iss_idx[d]);
      b_wb[d*IDXW +: IDXW]  = IDXW'(wb_idx[d]);
      o_iss[d*NREG +: NREG] = NREG'(1) << iss_idx[d];
      o_wb[d*NREG +: NREG]  = NREG'(1) << wb_idx[d];
    end
    for (int s = 0; s < NSRC; s++) begin
      b_src[s*IDXW +: IDXW] = IDXW'(src_idx[s]);
      o_src[s*NREG +: NREG] = NREG'(1) << src_idx[s];
    end
  end

  logic [NREG-1:0] pend_b, pend_o;
  logic haz_b, haz_o;

  wr_pend_scoreboard #(.NREG(NREG), .NSRC(NSRC), .NDST(NDST), .ONEHOT(1'b0)) dut (
    .clk(clk), .rst(rst), .iss_sel(iss_sel), .iss_wr(iss_wr), .iss_dst(b_iss),
    .wb_en(wb_en), .wb_dst(b_wb), .unit_busy(busy), .unit_done(done), .res_ok(rok),
    .chk_active(chk), .src_en(src_en), .src_sel(b_src), .pend(pend_b), .hazard(haz_b));

  wr_pend_scoreboard #(.NREG(NREG), .NSRC(NSRC), .NDST(NDST), .ONEHOT(1'b1)) dut_oh (
    .clk(clk), .rst(rst), .iss_sel(iss_sel), .iss_wr(iss_wr), .iss_dst(o_iss),
    .wb_en(wb_en), .wb_dst(o_wb), .unit_busy(busy), .unit_done(done), .res_ok(rok),
    .chk_active(chk), .src_en(src_en), .src_sel(o_src), .pend(pend_o), .hazard(haz_o));

  bit ref_pend[NREG];
  bit ref_lat[NDST];
  int ref_ldst[NDST];
  int n_checks = 0, n_errs = 0;
  bit finished = 0;
  string tag = "R1";

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_vec();
    logic [31:0] v = '0;
    for (int i = 0; i < NREG; i++) v[i] = ref_pend[i];
    return v;
  endfunction

  function automatic logic ref_haz();
    if (!chk) return 1'b0;
    for (int s = 0; s < NSRC; s++)
      if (src_en[s] && ref_pend[src_idx[s]]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic idle();
    iss_sel = '0; iss_wr = '0; wb_en = '0; busy = '0; done = '0; rok = '0;
    chk = 1'b0; src_en = '0;
    for (int d = 0; d < NDST; d++) begin iss_idx[d] = 0; wb_idx[d] = 0; end
    for (int s = 0; s < NSRC; s++) src_idx[s] = 0;
  endtask

  task automatic cycle();
    bit sets[NREG], clrs[NREG];
    #2;
    check({tag, " hazard bin"}, {31'd0, haz_b}, {31'd0, ref_haz()});
    check({tag, " hazard onehot R9"}, {31'd0, haz_o}, {31'd0, ref_haz()});
    @(posedge clk);
    if (rst) begin
      foreach (ref_pend[i]) ref_pend[i] = 0;
      foreach (ref_lat[d]) begin ref_lat[d] = 0; ref_ldst[d] = 0; end
    end else begin
      foreach (sets[i]) begin sets[i] = 0; clrs[i] = 0; end
      for (int d = 0; d < NDST; d++) begin
        if (iss_sel[d] && iss_wr[d]) sets[iss_idx[d]] = 1;
        if (wb_en[d]) clrs[wb_idx[d]] = 1;
        if (done[d] && ref_lat[d] && !rok[d]) clrs[ref_ldst[d]] = 1;
      end
      foreach (ref_pend[i]) if (sets[i]) ref_pend[i] = 1; else if (clrs[i]) ref_pend[i] = 0;
      for (int d = 0; d < NDST; d++) begin
        if (iss_sel[d]) begin ref_lat[d] = iss_wr[d]; ref_ldst[d] = iss_idx[d]; end
        else if (!busy[d]) ref_lat[d] = 0;
      end
    end
    @(negedge clk);
    check({tag, " pend bin"}, pend_b, ref_vec());
    check({tag, " pend onehot R9"}, pend_o, ref_vec());
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    tag = "R1"; rst = 1'b1; cycle(); cycle();
    check("R1 reset pend", pend_b, 32'h0);
    rst = 1'b0;

    tag = "R2";
    iss_sel = 2'b01; iss_wr = 2'b01; iss_idx[0] = 5; busy = 2'b01; cycle();
    check("R2 bit5 set", pend_b, 32'h20);
    iss_sel = 2'b10; iss_wr = 2'b00; iss_idx[1] = 9; busy = 2'b11; cycle();
    check("R2 no write flag", pend_b, 32'h20);

    tag = "R6"; iss_sel = '0;
    chk = 1; src_en = 3'b011; src_idx[0] = 1; src_idx[1] = 5; cycle();
    src_en = 3'b101; src_idx[2] = 7; cycle();
    src_en = 3'b000; src_idx[0] = 5; cycle();
    chk = 0; src_en = 3'b111; cycle();
    chk = 0; src_en = '0;

    tag = "R8";
    iss_sel = 2'b11; iss_wr = 2'b11; iss_idx[0] = 0; iss_idx[1] = 31; busy = 2'b11; cycle();
    check("R8 two sets", pend_b, 32'h8000_0021);
    iss_sel = '0;
    tag = "R3";
    wb_en = 2'b11; wb_idx[0] = 31; wb_idx[1] = 5; cycle();
    check("R3 R8 two clears", pend_b, 32'h1);
    wb_en = '0;

    tag = "R7";
    iss_sel = 2'b10; iss_wr = 2'b10; iss_idx[1] = 0; wb_en = 2'b01; wb_idx[0] = 0; cycle();
    check("R7 set wins", pend_b, 32'h1);
    iss_sel = '0; wb_en = '0;

    tag = "R4";
    iss_sel = 2'b01; iss_wr = 2'b01; iss_idx[0] = 12; busy = 2'b01; cycle();
    iss_sel = '0; done = 2'b01; rok = 2'b01; cycle();
    check("R4 ok result no clear", pend_b, 32'h1001);
    done = 2'b01; rok = 2'b00; cycle();
    check("R4 no-result clear", pend_b, 32'h0001);
    done = '0;

    tag = "R5";
    iss_sel = 2'b10; iss_wr = 2'b10; iss_idx[1] = 20; busy = 2'b10; cycle();
    iss_sel = '0; busy = 2'b00; cycle();
    done = 2'b10; rok = 2'b00; cycle();
    check("R5 dropped flag", pend_b, 32'h0010_0001);
    done = '0;

    tag = "R10"; cycle(); cycle();
    check("R10 hold", pend_b, 32'h0010_0001);

    tag = "R1"; rst = 1; cycle(); rst = 0;
    check("R1 reset again", pend_b, 32'h0);

    tag = "R8 random";
    for (int n = 0; n < 600; n++) begin
      iss_sel = 2'($urandom); iss_wr = 2'($urandom); wb_en = 2'($urandom);
      busy = 2'($urandom); done = 2'($urandom); rok = 2'($urandom);
      chk = 1'($urandom); src_en = 3'($urandom);
      for (int d = 0; d < NDST; d++) begin
        iss_idx[d] = int'($urandom_range(0, 7)); wb_idx[d] = int'($urandom_range(0, 7));
      end
      for (int s = 0; s < NSRC; s++) src_idx[s] = int'($urandom_range(0, 7));
      cycle();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule